// File: doc/BRIEF.md
# I/O Subchannel Status and Termination Logic

This block follows a single I/O subchannel through one data transfer. A start strobe opens the operation. It latches five command flags and loads a byte count. From then on the block watches the count decrements and the device's channel-end and unusual-end pulses. It also watches transmission errors (parity or overrun), memory write-lock violations and processor halt requests. From these it builds a six-bit operation status byte. It decides when the device controller must be halted and when the operation terminates with unusual end. It also raises an interrupt request that software clears by acknowledging a status read.

Incorrect length is found from the order of two events: the count running out and the device reporting channel end. A suppress flag decides whether incorrect length counts as an error. The suppress flag and the halt-on-error flag together decide whether incorrect length stops the device. Once a channel end or a device halt has closed the operation, further stimulus is ignored until the next start. The block also presents a response word made of the device's own status byte, the operation status byte, and reserved bits that read as zero.

Top module: `subch_status_unit`

## Requirements
- R1: Reset clears the status byte, `term_unusual_o`, `dev_halt_o`, `irq_o` and `fault_o`, and leaves the subchannel inactive. A `start_i` pulse does four things: it latches `flags_i`, loads `count_init_i`, clears the status byte and `term_unusual_o`, and makes the subchannel active. The flag encoding is `flags_i[0]` suppress-incorrect-length, `[1]` halt-on-error, `[2]` interrupt-on-zero-count, `[3]` interrupt-on-channel-end, `[4]` interrupt-on-unusual-end.
- R2: `status_o[1]` (transmission data error) is set by any `xfer_err_i` pulse while active. It holds until the next start or acknowledge.
- R3: `status_o[0]` (incorrect length) is set in two cases. The first is channel end while the byte count, after any decrement in that cycle, is still nonzero. The second is a decrement that brings the count to zero in a cycle without channel end. A decrement to zero in the same cycle as channel end is a correct length.
- R4: `fault_o` is high when the status byte holds a transmission data error, or a write-lock violation, or an incorrect length with the latched suppress flag at 0. An incorrect length under suppress flag 1 is reported in `status_o[0]` and does not raise `fault_o`.
- R5: `dev_halt_o` is a pulse of one cycle, in the cycle after its cause. The causes are:
  - a processor halt request;
  - a transmission error with halt-on-error set;
  - an incorrect-length event with suppress at 0 and halt-on-error at 1;
  - a termination (R9).
- R6: `status_o[2]` is set when a decrement brings the count to zero and interrupt-on-zero-count is 1.
- R7: `status_o[3]` is set on channel end while active when interrupt-on-channel-end is 1.
- R8: `status_o[4]` is set when interrupt-on-unusual-end is 1 and one of three things happens while active: a device unusual-end pulse, a processor halt request, or a termination.
- R9: `status_o[5]` is set on a write-lock violation while active. If halt-on-error and interrupt-on-unusual-end are both 1, the operation terminates. `term_unusual_o` then rises and stays high until the next start, and the device is halted.
- R10: `irq_o` is high while any of `status_o[4:2]` is set. A `status_ack_i` clears the whole status byte one cycle later. An event in the same cycle as the acknowledge still sets its bit.
- R11: `resp_o[7:0]` equals `dev_stat_i`, `resp_o[15:8]` equals `status_o`, and `status_o[7:6]` and `resp_o[18:16]` are always zero.
- R12: After a channel end or a device halt, every event input is ignored until the next start. Events in the same cycle as `start_i` are also ignored.
- R13: A decrement at a count of zero is ignored. The count does not wrap, and a later channel end is not an incorrect length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-I/O accepted strobe |
| flags_i | input | 5 | Command flags, sampled at start |
| count_init_i | input | CNT_W | Initial byte count |
| cnt_dec_i | input | 1 | Byte count decrement strobe |
| chan_end_i | input | 1 | Device channel-end pulse |
| unus_end_i | input | 1 | Device unusual-end pulse |
| xfer_err_i | input | 1 | Parity or overrun error pulse |
| wlock_i | input | 1 | Memory write-lock violation pulse |
| halt_req_i | input | 1 | Processor halt request |
| status_ack_i | input | 1 | Status read acknowledge |
| dev_stat_i | input | 8 | Device and controller status byte |
| status_o | output | 8 | Operation status byte |
| dev_halt_o | output | 1 | Device halt strobe |
| irq_o | output | 1 | Interrupt request |
| term_unusual_o | output | 1 | Operation terminated with unusual end |
| fault_o | output | 1 | Status byte holds an error condition |
| resp_o | output | 19 | Response word |

## Verification
The bench builds the block with a 4-bit byte count and starts every operation at a count of three. This keeps the zero boundary, the early and late channel-end orders, and a decrement below zero only a few strobes apart. Within that small setting it runs each of seven event sequences under all 32 flag combinations, and computes every expected status bit, halt count and response word from the flag values. Directed cases then cover start and acknowledge colliding with events, and the count held at zero.

// File: rtl/subch_pkg.sv
package subch_pkg;
  typedef struct packed {
    logic iue;  // interrupt on unusual end
    logic ice;  // interrupt on channel end
    logic izc;  // interrupt on zero count
    logic hte;  // halt on error
    logic sil;  // suppress incorrect length
  } cmd_flags_t;

  localparam int FLAG_W  = $bits(cmd_flags_t);
  localparam int DEV_W   = 8;
  localparam int ST_W    = 8;
  localparam int ST_USED = 6;
  localparam int RESP_W  = 19;
  localparam int RSV_W   = RESP_W - DEV_W - ST_W;

  localparam int ST_IL  = 0;
  localparam int ST_TDE = 1;
  localparam int ST_ZC  = 2;
  localparam int ST_CE  = 3;
  localparam int ST_UE  = 4;
  localparam int ST_WL  = 5;
endpackage

// File: rtl/subch_byte_counter.sv
module subch_byte_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             dec_i,
  output logic             zero_hit_o,
  output logic             left_nz_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_after;
  logic             can_dec;

  // decrement saturates at zero
  assign can_dec    = dec_i & (cnt_q != '0);
  assign cnt_after  = cnt_q - CNT_W'(can_dec);
  assign zero_hit_o = can_dec & (cnt_q == CNT_W'(1));
  assign left_nz_o  = (cnt_after != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= init_i;
    else             cnt_q <= cnt_after;
  end
endmodule

// File: rtl/subch_status_reg.sv
module subch_status_reg
  import subch_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ST_USED-1:0] set_i,
  input  logic               clr_i,
  output logic [ST_W-1:0]    status_o
);
  for (genvar gi = 0; gi < ST_W; gi++) begin : g_bit
    if (gi < ST_USED) begin : g_live
      logic bit_q;
      // a set in the clearing cycle wins
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        bit_q <= 1'b0;
        else if (set_i[gi]) bit_q <= 1'b1;
        else if (clr_i)     bit_q <= 1'b0;
      end
      assign status_o[gi] = bit_q;
    end else begin : g_rsv
      assign status_o[gi] = 1'b0;
    end
  end
endmodule

// File: rtl/subch_term_ctl.sv
module subch_term_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ce_ev_i,
  input  logic hr_ev_i,
  input  logic err_ev_i,
  input  logic wl_ev_i,
  input  logic il_ev_i,
  input  logic sil_i,
  input  logic hte_i,
  input  logic iue_i,
  output logic active_o,
  output logic term_ev_o,
  output logic dev_halt_o,
  output logic term_o
);
  logic active_q, halt_q, term_q;
  logic halt_cause;

  assign term_ev_o  = wl_ev_i & hte_i & iue_i;
  assign halt_cause = hr_ev_i
                    | (err_ev_i & hte_i)
                    | (il_ev_i & ~sil_i & hte_i)
                    | term_ev_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      halt_q   <= 1'b0;
      term_q   <= 1'b0;
    end else begin
      halt_q <= halt_cause;
      if (start_i) begin
        active_q <= 1'b1;
        term_q   <= 1'b0;
      end else begin
        if (halt_cause | ce_ev_i) active_q <= 1'b0;
        if (term_ev_o)            term_q   <= 1'b1;
      end
    end
  end

  assign active_o   = active_q;
  assign dev_halt_o = halt_q;
  assign term_o     = term_q;
endmodule

// File: rtl/subch_status_unit.sv
module subch_status_unit
  import subch_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [4:0]        flags_i,
  input  logic [CNT_W-1:0]  count_init_i,
  input  logic              cnt_dec_i,
  input  logic              chan_end_i,
  input  logic              unus_end_i,
  input  logic              xfer_err_i,
  input  logic              wlock_i,
  input  logic              halt_req_i,
  input  logic              status_ack_i,
  input  logic [7:0]        dev_stat_i,
  output logic [7:0]        status_o,
  output logic              dev_halt_o,
  output logic              irq_o,
  output logic              term_unusual_o,
  output logic              fault_o,
  output logic [18:0]       resp_o
);
  cmd_flags_t flags_q;
  logic active, ev_ok;
  logic dec_q, ce_q, ue_q, err_q, wl_q, hr_q;
  logic zero_hit, left_nz, il_ev, term_ev;
  logic [ST_USED-1:0] set_v;
  logic [ST_W-1:0]    st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= '0;
    else if (start_i) flags_q <= cmd_flags_t'(flags_i);
  end

  // events count only inside an open operation; start has priority
  assign ev_ok = active & ~start_i;
  assign dec_q = ev_ok & cnt_dec_i;
  assign ce_q  = ev_ok & chan_end_i;
  assign ue_q  = ev_ok & unus_end_i;
  assign err_q = ev_ok & xfer_err_i;
  assign wl_q  = ev_ok & wlock_i;
  assign hr_q  = ev_ok & halt_req_i;

  subch_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_i),
    .init_i     (count_init_i),
    .dec_i      (dec_q),
    .zero_hit_o (zero_hit),
    .left_nz_o  (left_nz)
  );

  // ordering of count-done against channel end
  assign il_ev = (ce_q & left_nz) | (zero_hit & ~ce_q);

  subch_term_ctl u_term (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ce_ev_i    (ce_q),
    .hr_ev_i    (hr_q),
    .err_ev_i   (err_q),
    .wl_ev_i    (wl_q),
    .il_ev_i    (il_ev),
    .sil_i      (flags_q.sil),
    .hte_i      (flags_q.hte),
    .iue_i      (flags_q.iue),
    .active_o   (active),
    .term_ev_o  (term_ev),
    .dev_halt_o (dev_halt_o),
    .term_o     (term_unusual_o)
  );

  always_comb begin
    set_v         = '0;
    set_v[ST_IL]  = il_ev;
    set_v[ST_TDE] = err_q;
    set_v[ST_ZC]  = zero_hit & flags_q.izc;
    set_v[ST_CE]  = ce_q & flags_q.ice;
    set_v[ST_UE]  = flags_q.iue & (ue_q | hr_q | term_ev);
    set_v[ST_WL]  = wl_q;
  end

  subch_status_reg u_st (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_v),
    .clr_i    (start_i | status_ack_i),
    .status_o (st)
  );

  assign status_o = st;
  assign irq_o    = st[ST_ZC] | st[ST_CE] | st[ST_UE];
  assign fault_o  = st[ST_TDE] | st[ST_WL] | (st[ST_IL] & ~flags_q.sil);
  assign resp_o   = {{RSV_W{1'b0}}, st, dev_stat_i};
endmodule

// File: rtl/subch_status_chk.sv
module subch_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       status_ack_i,
  input logic       cnt_dec_i,
  input logic       chan_end_i,
  input logic       unus_end_i,
  input logic       xfer_err_i,
  input logic       wlock_i,
  input logic       halt_req_i,
  input logic [7:0] status_o,
  input logic       dev_halt_o,
  input logic       term_unusual_o,
  input logic       irq_o
);
  logic any_ev;
  assign any_ev = cnt_dec_i | chan_end_i | unus_end_i | xfer_err_i | wlock_i | halt_req_i;

  a_r1_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (status_o == 8'h00) && !term_unusual_o);

  a_r2_tde_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1] && !start_i && !status_ack_i |=> status_o[1]);

  a_r5_halt_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_halt_o |=> !dev_halt_o);

  a_r5_halt_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_halt_o |-> $past(any_ev));

  a_r9_term_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_unusual_o && !start_i |=> term_unusual_o);

  a_r10_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_ack_i && !start_i && !any_ev |=> !irq_o && (status_o == 8'h00));
endmodule

bind subch_status_unit subch_status_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .status_ack_i   (status_ack_i),
  .cnt_dec_i      (cnt_dec_i),
  .chan_end_i     (chan_end_i),
  .unus_end_i     (unus_end_i),
  .xfer_err_i     (xfer_err_i),
  .wlock_i        (wlock_i),
  .halt_req_i     (halt_req_i),
  .status_o       (status_o),
  .dev_halt_o     (dev_halt_o),
  .term_unusual_o (term_unusual_o),
  .irq_o          (irq_o)
);

// File: tb/subch_status_unit_tb.sv
`timescale 1ns/1ps
module subch_status_unit_tb;
  localparam int CNT_W = 4;
  localparam logic [5:0] DEC = 6'd1, CE = 6'd2, UE = 6'd4, ERR = 6'd8, WL = 6'd16, HR = 6'd32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start, cnt_dec, chan_end, unus_end, xfer_err, wlock, halt_req, ack;
  logic [4:0] flags;
  logic [CNT_W-1:0] cnt_init;
  logic [7:0] dev_stat, status;
  logic dev_halt, irq, term, fault;
  logic [18:0] resp;

  int checks = 0, errors = 0, halt_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(negedge clk) if (dev_halt) halt_cnt++;

  subch_status_unit #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .flags_i(flags),
    .count_init_i(cnt_init), .cnt_dec_i(cnt_dec), .chan_end_i(chan_end),
    .unus_end_i(unus_end), .xfer_err_i(xfer_err), .wlock_i(wlock),
    .halt_req_i(halt_req), .status_ack_i(ack), .dev_stat_i(dev_stat),
    .status_o(status), .dev_halt_o(dev_halt), .irq_o(irq),
    .term_unusual_o(term), .fault_o(fault), .resp_o(resp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus; return just after the next falling edge
  task automatic cyc(input logic [5:0] ev, input logic st, input logic ak);
    cnt_dec = ev[0]; chan_end = ev[1]; unus_end = ev[2];
    xfer_err = ev[3]; wlock = ev[4]; halt_req = ev[5];
    start = st; ack = ak;
    @(posedge clk);
    @(negedge clk);
    #1;
    {cnt_dec, chan_end, unus_end, xfer_err, wlock, halt_req, start, ack} = '0;
  endtask

  task automatic do_start(input logic [4:0] f, input logic [CNT_W-1:0] n);
    flags = f; cnt_init = n;
    cyc(6'd0, 1'b1, 1'b0);
    halt_cnt = 0;
  endtask

  function automatic logic [5:0] seq_ev(input int sc, input int st);
    case (sc)
      0: return (st < 2) ? DEC : (st == 2) ? (DEC | CE) : 6'd0;
      1: return (st == 0) ? DEC : (st == 1) ? CE : 6'd0;
      2: return (st < 3) ? DEC : CE;
      3: return (st == 1) ? ERR : (st == 3) ? (DEC | CE) : DEC;
      4: return (st == 1) ? UE : (st == 3) ? (DEC | CE) : DEC;
      5: return (st == 1) ? HR : (st == 3) ? CE : DEC;
      default: return (st == 1) ? WL : (st == 3) ? (DEC | CE) : DEC;
    endcase
  endfunction

  initial begin
    {start, cnt_dec, chan_end, unus_end, xfer_err, wlock, halt_req, ack} = '0;
    flags = '0; cnt_init = '0; dev_stat = 8'h3C;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset status", status, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset halt", dev_halt, 0);
    chk("R1 reset term", term, 0);
    chk("R1 reset fault", fault, 0);
    chk("R11 reset resp", resp, 19'h0003C);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R12: inactive after reset, events ignored
    cyc(ERR | CE | WL, 1'b0, 1'b0);
    chk("R12 inactive ignores events", status, 0);

    // sweep: 7 sequences x 32 flag settings
    for (int sc = 0; sc < 7; sc++) begin
      for (int f = 0; f < 32; f++) begin
        logic sil, hte, izc, ice, iue;
        logic e_il, e_tde, e_zc, e_ce, e_ue, e_wl, e_term, h;
        int e_halts;
        logic [7:0] e_st;
        sil = f[0]; hte = f[1]; izc = f[2]; ice = f[3]; iue = f[4];
        e_il = 0; e_tde = 0; e_zc = izc; e_ce = ice; e_ue = 0; e_wl = 0; e_term = 0; e_halts = 0;
        case (sc)
          1: begin e_il = 1; e_zc = 0; e_halts = (!sil && hte) ? 1 : 0; end
          2: begin e_il = 1; h = !sil && hte; e_ce = h ? 1'b0 : ice; e_halts = h ? 1 : 0; end
          3: begin e_tde = 1; h = hte;
                   if (h) begin e_zc = 0; e_ce = 0; e_halts = 1; end end
          4: begin e_ue = iue; end
          5: begin e_ue = iue; e_zc = 0; e_ce = 0; e_halts = 1; end
          6: begin e_wl = 1; h = hte && iue; e_term = h; e_ue = h;
                   if (h) begin e_zc = 0; e_ce = 0; e_halts = 1; end end
          default: ;
        endcase
        e_st = {2'b00, e_wl, e_ue, e_ce, e_zc, e_tde, e_il};
        dev_stat = 8'(8'hA5 ^ (sc * 32 + f));
        do_start(5'(f), 4'd3);
        chk("R1 start clears status", status, 0);
        for (int st = 0; st < 4; st++) cyc(seq_ev(sc, st), 1'b0, 1'b0);
        cyc(6'd0, 1'b0, 1'b0);
        chk("R3 incorrect length", status[0], e_il);
        chk("R2 transmission error sticky", status[1], e_tde);
        chk("R6 zero count", status[2], e_zc);
        chk("R7 channel end", status[3], e_ce);
        chk("R8 unusual end", status[4], e_ue);
        chk("R9 write lock", status[5], e_wl);
        chk("R9 terminate", term, e_term);
        chk("R4 fault", fault, e_tde | e_wl | (e_il & !sil));
        chk("R5 halt pulses", halt_cnt, e_halts);
        chk("R10 irq", irq, e_zc | e_ce | e_ue);
        chk("R11 response", resp, {3'b000, e_st, dev_stat});
        cyc(6'd0, 1'b0, 1'b1);
        chk("R10 ack clears status", status, 0);
        chk("R10 ack drops irq", irq, 0);
        cyc(ERR | WL | HR | DEC, 1'b0, 1'b0);
        chk("R12 ended op ignores events", status, 0);
        chk("R12 ended op no halt", halt_cnt, e_halts);
      end
    end

    // R12: events in the start cycle are ignored
    do_start(5'b01000, 4'd2);
    cyc(ERR | CE, 1'b1, 1'b0);
    chk("R12 start wins over events", status, 0);
    cyc(CE, 1'b0, 1'b0);
    chk("R12 op still open after start", status, 8'h09);

    // R10: event in the ack cycle sets its bit
    do_start(5'b01000, 4'd0);
    cyc(CE, 1'b0, 1'b1);
    chk("R10 event beats ack", status, 8'h08);
    chk("R10 irq after event with ack", irq, 1);

    // R13: count held at zero
    do_start(5'b00101, 4'd1);
    cyc(DEC, 1'b0, 1'b0);
    chk("R13 reach zero", status, 8'h05);
    chk("R4 suppressed length no fault", fault, 0);
    cyc(6'd0, 1'b0, 1'b1);
    cyc(DEC, 1'b0, 1'b0);
    chk("R13 dec at zero ignored", status, 0);
    cyc(CE, 1'b0, 1'b0);
    chk("R13 no wrap, no incorrect length", status, 0);

    // R9/R1: terminate then restart clears term
    do_start(5'b10010, 4'd3);
    cyc(WL, 1'b0, 1'b0);
    cyc(6'd0, 1'b0, 1'b1);
    chk("R9 term holds through ack", term, 1);
    do_start(5'b00000, 4'd3);
    chk("R1 start clears term", term, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule